// File: doc/BRIEF.md
# 2D Blit Parameter Register Front End

This block holds the operand parameters for a 2D block-transfer engine and tells that engine when to start. Software performs 32-bit word writes into a small address space. Some registers each hold one field. Others are packed registers that set two fields at once, and several of these alias the same fields with the halves in opposite order. The block unpacks each write into source and destination X/Y coordinates, destination width and height, and source and destination surface offset, pitch and tile flag. All of these values are presented continuously on output ports.

Only some writes launch the engine: those to a register that carries the destination width. After such a write is accepted, a single-cycle start pulse appears on the next cycle. By then the updated fields are already visible on the outputs, so the engine can sample every operand on the pulse. The block does not move data, apply raster operations or access memory.

Top module: `blit_param_regs`

## Requirements
- R1: After reset every field output is zero and `blitStart` is low.
- R2: Single-field coordinate registers take bits 13:0 of the written word: source X at address 0, source Y at 1, destination X at 2, destination Y at 3, width at 4 and height at 5.
- R3: The Y-X packed registers put X in bits 13:0 and Y in bits 29:16. Source is at address 6 and destination at 7. The X-Y packed registers reverse the halves, with Y in bits 13:0 and X in bits 29:16. Source is at address 8 and destination at 9.
- R4: Packed size and position registers work as follows. Address 10 takes width from bits 13:0 and height from bits 29:16. Address 11 takes height from bits 13:0 and width from bits 29:16. Address 12 takes destination X from bits 13:0 and width from bits 29:16. Address 13 takes destination Y from bits 13:0 and height from bits 29:16.
- R5: A write to address 4, 10, 11 or 12 makes `blitStart` high for exactly the one cycle that follows the write. In that cycle the fields from that write are already on the outputs.
- R6: A write to any other address, including the height registers at 5 and 13, leaves `blitStart` low.
- R7: The packed surface registers are at address 18 for source and 19 for destination. Each sets offset to bits 21:0 shifted left by 10, pitch to bits 29:22 placed at pitch bits 13:6, and tile to bit 30.
- R8: The separate offset registers are at address 14 for source and 16 for destination. They keep the written word under mask 0xFFFFFC00. The separate pitch registers are at 15 for source and 17 for destination. They keep the written word under mask 0x3FF0. Neither kind changes the tile flag.
- R9: Writes to addresses 20 to 31 change no output and start nothing.
- R10: When `wrEn` is low, the address and data inputs change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 5 | Word address of the write |
| wrData | input | 32 | Write data |
| srcX | output | 14 | Source X |
| srcY | output | 14 | Source Y |
| dstX | output | 14 | Destination X |
| dstY | output | 14 | Destination Y |
| dstWidth | output | 14 | Destination width |
| dstHeight | output | 14 | Destination height |
| srcOffset | output | 32 | Source surface offset |
| srcPitch | output | 14 | Source pitch |
| srcTile | output | 1 | Source tile flag |
| dstOffset | output | 32 | Destination surface offset |
| dstPitch | output | 14 | Destination pitch |
| dstTile | output | 1 | Destination tile flag |
| blitStart | output | 1 | One-cycle launch pulse |

## Verification
The bench writes distinct values into both halves of every aliased packed register. A design that swapped the halves of the X-Y and Y-X variants, or of the height-width and width-height variants, would show X and Y, or width and height, exchanged. It writes the height and height-Y registers, where a design that launched on any size write would pulse `blitStart`. It also issues back-to-back width writes, where a pulse that was stretched or dropped would be visible.

For the surface registers, the bench writes all-ones words. This shows whether a masked or shifted bit leaks into offset or pitch. It also shows whether a separate pitch write wrongly clears the tile flag. The remaining cases are writes to unmapped addresses and data that changes while `wrEn` is low. A design that decoded carelessly would alter a field in either case.

// File: rtl/blit_pkg.sv
package blit_pkg;

  localparam int A_SRC_X   = 0;
  localparam int A_SRC_Y   = 1;
  localparam int A_DST_X   = 2;
  localparam int A_DST_Y   = 3;
  localparam int A_WIDTH   = 4;
  localparam int A_HEIGHT  = 5;
  localparam int A_SRC_YX  = 6;
  localparam int A_DST_YX  = 7;
  localparam int A_SRC_XY  = 8;
  localparam int A_DST_XY  = 9;
  localparam int A_HW      = 10;
  localparam int A_WH      = 11;
  localparam int A_WX      = 12;
  localparam int A_HY      = 13;
  localparam int A_SRC_OFF = 14;
  localparam int A_SRC_PIT = 15;
  localparam int A_DST_OFF = 16;
  localparam int A_DST_PIT = 17;
  localparam int A_SRC_PK  = 18;
  localparam int A_DST_PK  = 19;

  localparam int NUM_FLD = 6;
  localparam int F_SRCX  = 0;
  localparam int F_SRCY  = 1;
  localparam int F_DSTX  = 2;
  localparam int F_DSTY  = 3;
  localparam int F_WIDTH = 4;
  localparam int F_HGT   = 5;

  typedef struct packed {
    logic ld;
    logic hi;
  } fld_stb_t;

  // index 0 = source surface, 1 = destination surface
  typedef struct packed {
    fld_stb_t [NUM_FLD-1:0] fld;
    logic [1:0]             ldOff;
    logic [1:0]             ldPitch;
    logic [1:0]             ldPacked;
  } strobe_t;

endpackage

// File: rtl/blit_ctrl.sv
module blit_ctrl
  import blit_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output strobe_t           stb,
  output logic              blitStart
);

  logic launch;

  always_comb begin
    stb    = '0;
    launch = 1'b0;
    if (wrEn) begin
      case (int'(wrAddr))
        A_SRC_X:   stb.fld[F_SRCX].ld = 1'b1;
        A_SRC_Y:   stb.fld[F_SRCY].ld = 1'b1;
        A_DST_X:   stb.fld[F_DSTX].ld = 1'b1;
        A_DST_Y:   stb.fld[F_DSTY].ld = 1'b1;
        A_WIDTH: begin
          stb.fld[F_WIDTH].ld = 1'b1;
          launch = 1'b1;
        end
        A_HEIGHT:  stb.fld[F_HGT].ld = 1'b1;
        A_SRC_YX: begin
          stb.fld[F_SRCX].ld = 1'b1;
          stb.fld[F_SRCY] = '{ld: 1'b1, hi: 1'b1};
        end
        A_DST_YX: begin
          stb.fld[F_DSTX].ld = 1'b1;
          stb.fld[F_DSTY] = '{ld: 1'b1, hi: 1'b1};
        end
        A_SRC_XY: begin
          stb.fld[F_SRCY].ld = 1'b1;
          stb.fld[F_SRCX] = '{ld: 1'b1, hi: 1'b1};
        end
        A_DST_XY: begin
          stb.fld[F_DSTY].ld = 1'b1;
          stb.fld[F_DSTX] = '{ld: 1'b1, hi: 1'b1};
        end
        A_HW: begin
          stb.fld[F_WIDTH].ld = 1'b1;
          stb.fld[F_HGT] = '{ld: 1'b1, hi: 1'b1};
          launch = 1'b1;
        end
        A_WH: begin
          stb.fld[F_HGT].ld = 1'b1;
          stb.fld[F_WIDTH] = '{ld: 1'b1, hi: 1'b1};
          launch = 1'b1;
        end
        A_WX: begin
          stb.fld[F_DSTX].ld = 1'b1;
          stb.fld[F_WIDTH] = '{ld: 1'b1, hi: 1'b1};
          launch = 1'b1;
        end
        A_HY: begin
          stb.fld[F_DSTY].ld = 1'b1;
          stb.fld[F_HGT] = '{ld: 1'b1, hi: 1'b1};
        end
        A_SRC_OFF: stb.ldOff[0]    = 1'b1;
        A_SRC_PIT: stb.ldPitch[0]  = 1'b1;
        A_DST_OFF: stb.ldOff[1]    = 1'b1;
        A_DST_PIT: stb.ldPitch[1]  = 1'b1;
        A_SRC_PK:  stb.ldPacked[0] = 1'b1;
        A_DST_PK:  stb.ldPacked[1] = 1'b1;
        default: ;
      endcase
    end
  end

  // registered so the pulse lines up with the freshly loaded fields
  always_ff @(posedge clk) begin
    if (!rstN) blitStart <= 1'b0;
    else       blitStart <= launch;
  end

endmodule

// File: rtl/blit_datapath.sv
module blit_datapath
  import blit_pkg::*;
#(
  parameter int COORD_W = 14,
  parameter int OFF_W   = 32,
  parameter int PITCH_W = 14,
  parameter int DATA_W  = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  strobe_t                          stb,
  input  logic [DATA_W-1:0]                wrData,
  output logic [NUM_FLD-1:0][COORD_W-1:0]  coord,
  output logic [1:0][OFF_W-1:0]            offset,
  output logic [1:0][PITCH_W-1:0]          pitch,
  output logic [1:0]                       tile
);

  localparam int HI_LSB     = 16;
  localparam int OFF_LSB    = 10;
  localparam int PIT_LSB    = 4;
  localparam int PK_PIT_W   = 8;
  localparam int PK_PIT_SRC = 22;
  localparam int PK_PIT_LSB = PITCH_W - PK_PIT_W;
  localparam int PK_OFF_W   = OFF_W - OFF_LSB;
  localparam int TILE_BIT   = 30;

  logic [COORD_W-1:0] loHalf, hiHalf;
  assign loHalf = wrData[COORD_W-1:0];
  assign hiHalf = wrData[HI_LSB +: COORD_W];

  for (genvar f = 0; f < NUM_FLD; f++) begin : g_fld
    always_ff @(posedge clk) begin
      if (!rstN)              coord[f] <= '0;
      else if (stb.fld[f].ld) coord[f] <= stb.fld[f].hi ? hiHalf : loHalf;
    end
  end

  for (genvar s = 0; s < 2; s++) begin : g_surf
    always_ff @(posedge clk) begin
      if (!rstN) begin
        offset[s] <= '0;
        pitch[s]  <= '0;
        tile[s]   <= 1'b0;
      end else if (stb.ldPacked[s]) begin
        offset[s] <= {wrData[PK_OFF_W-1:0], {OFF_LSB{1'b0}}};
        pitch[s]  <= {wrData[PK_PIT_SRC +: PK_PIT_W], {PK_PIT_LSB{1'b0}}};
        tile[s]   <= wrData[TILE_BIT];
      end else begin
        if (stb.ldOff[s])
          offset[s] <= {wrData[OFF_W-1:OFF_LSB], {OFF_LSB{1'b0}}};
        if (stb.ldPitch[s])
          pitch[s] <= {wrData[PITCH_W-1:PIT_LSB], {PIT_LSB{1'b0}}};
      end
    end
  end

endmodule

// File: rtl/blit_param_regs.sv
module blit_param_regs
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int COORD_W = 14,
  parameter int OFF_W   = 32,
  parameter int PITCH_W = 14
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [31:0]        wrData,
  output logic [COORD_W-1:0] srcX,
  output logic [COORD_W-1:0] srcY,
  output logic [COORD_W-1:0] dstX,
  output logic [COORD_W-1:0] dstY,
  output logic [COORD_W-1:0] dstWidth,
  output logic [COORD_W-1:0] dstHeight,
  output logic [OFF_W-1:0]   srcOffset,
  output logic [PITCH_W-1:0] srcPitch,
  output logic               srcTile,
  output logic [OFF_W-1:0]   dstOffset,
  output logic [PITCH_W-1:0] dstPitch,
  output logic               dstTile,
  output logic               blitStart
);

  strobe_t                          stb;
  logic [NUM_FLD-1:0][COORD_W-1:0]  coord;
  logic [1:0][OFF_W-1:0]            offset;
  logic [1:0][PITCH_W-1:0]          pitch;
  logic [1:0]                       tile;

  blit_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .stb(stb), .blitStart(blitStart)
  );

  blit_datapath #(.COORD_W(COORD_W), .OFF_W(OFF_W), .PITCH_W(PITCH_W), .DATA_W(32)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .coord(coord), .offset(offset), .pitch(pitch), .tile(tile)
  );

  assign srcX      = coord[F_SRCX];
  assign srcY      = coord[F_SRCY];
  assign dstX      = coord[F_DSTX];
  assign dstY      = coord[F_DSTY];
  assign dstWidth  = coord[F_WIDTH];
  assign dstHeight = coord[F_HGT];
  assign srcOffset = offset[0];
  assign srcPitch  = pitch[0];
  assign srcTile   = tile[0];
  assign dstOffset = offset[1];
  assign dstPitch  = pitch[1];
  assign dstTile   = tile[1];

endmodule

// File: rtl/blit_param_checker.sv
module blit_param_checker
  import blit_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int COORD_W = 14,
  parameter int OFF_W   = 32,
  parameter int PITCH_W = 14
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [ADDR_W-1:0]  wrAddr,
  input logic [31:0]        wrData,
  input logic [COORD_W-1:0] srcX,
  input logic [COORD_W-1:0] srcY,
  input logic [COORD_W-1:0] dstX,
  input logic [COORD_W-1:0] dstY,
  input logic [COORD_W-1:0] dstWidth,
  input logic [COORD_W-1:0] dstHeight,
  input logic [OFF_W-1:0]   srcOffset,
  input logic [PITCH_W-1:0] srcPitch,
  input logic               srcTile,
  input logic [OFF_W-1:0]   dstOffset,
  input logic [PITCH_W-1:0] dstPitch,
  input logic               dstTile,
  input logic               blitStart
);

  logic isLaunch;
  assign isLaunch = wrEn && (int'(wrAddr) == A_WIDTH || int'(wrAddr) == A_HW ||
                             int'(wrAddr) == A_WH || int'(wrAddr) == A_WX);

  p_start_after_launch_r5: assert property (@(posedge clk) disable iff (!rstN)
    isLaunch |=> blitStart);

  p_no_spurious_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    !isLaunch |=> !blitStart);

  p_width_on_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrAddr) == A_WIDTH) |=> (blitStart && dstWidth == $past(wrData[COORD_W-1:0])));

  p_unknown_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrAddr) > A_DST_PK) |=>
      ($stable(srcX) && $stable(srcY) && $stable(dstX) && $stable(dstY) &&
       $stable(dstWidth) && $stable(dstHeight) && $stable(srcOffset) &&
       $stable(dstOffset) && $stable(srcPitch) && $stable(dstPitch) &&
       $stable(srcTile) && $stable(dstTile)));

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(srcX) && $stable(dstWidth) && $stable(dstOffset) && $stable(srcPitch)));

  p_xy_swap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(wrAddr) == A_SRC_XY) |=>
      (srcY == $past(wrData[COORD_W-1:0]) && srcX == $past(wrData[16 +: COORD_W])));

endmodule

bind blit_param_regs blit_param_checker #(
  .ADDR_W(ADDR_W), .COORD_W(COORD_W), .OFF_W(OFF_W), .PITCH_W(PITCH_W)
) u_chk (.*);

// File: tb/tb_blit_param_regs.sv
`timescale 1ns/1ps
module tb_blit_param_regs;
  import blit_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [13:0] srcX, srcY, dstX, dstY, dstWidth, dstHeight, srcPitch, dstPitch;
  logic [31:0] srcOffset, dstOffset;
  logic        srcTile, dstTile, blitStart;

  always #4 clk = ~clk;

  blit_param_regs dut (.*);

  typedef struct {
    logic [13:0] sx, sy, dx, dy, w, h, sp, dp;
    logic [31:0] so, dof;
    logic        st, dt, go;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t m;
  int   nChk = 0, nFail = 0;
  bit   done = 1'b0;

  function automatic logic [179:0] pack(exp_t e);
    return {e.sx, e.sy, e.dx, e.dy, e.w, e.h, e.sp, e.dp, e.so, e.dof, e.st, e.dt, e.go};
  endfunction

  function automatic logic [179:0] actual();
    return {srcX, srcY, dstX, dstY, dstWidth, dstHeight, srcPitch, dstPitch,
            srcOffset, dstOffset, srcTile, dstTile, blitStart};
  endfunction

  task automatic check(string tag, logic [179:0] act, logic [179:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: present one write and queue the state expected after it
  task automatic doWrite(int a, logic [31:0] d, bit en, string tag);
    @(negedge clk);
    wrEn = en; wrAddr = 5'(a); wrData = d;
    m.go = 1'b0;
    m.tag = tag;
    if (en) begin
      case (a)
        A_SRC_X: m.sx = d[13:0];
        A_SRC_Y: m.sy = d[13:0];
        A_DST_X: m.dx = d[13:0];
        A_DST_Y: m.dy = d[13:0];
        A_WIDTH: begin m.w = d[13:0]; m.go = 1'b1; end
        A_HEIGHT: m.h = d[13:0];
        A_SRC_YX: begin m.sx = d[13:0]; m.sy = d[29:16]; end
        A_DST_YX: begin m.dx = d[13:0]; m.dy = d[29:16]; end
        A_SRC_XY: begin m.sy = d[13:0]; m.sx = d[29:16]; end
        A_DST_XY: begin m.dy = d[13:0]; m.dx = d[29:16]; end
        A_HW: begin m.w = d[13:0]; m.h = d[29:16]; m.go = 1'b1; end
        A_WH: begin m.h = d[13:0]; m.w = d[29:16]; m.go = 1'b1; end
        A_WX: begin m.dx = d[13:0]; m.w = d[29:16]; m.go = 1'b1; end
        A_HY: begin m.dy = d[13:0]; m.h = d[29:16]; end
        A_SRC_OFF: m.so = d & 32'hFFFF_FC00;
        A_SRC_PIT: m.sp = 14'(d & 32'h3FF0);
        A_DST_OFF: m.dof = d & 32'hFFFF_FC00;
        A_DST_PIT: m.dp = 14'(d & 32'h3FF0);
        A_SRC_PK: begin
          m.so = (d & 32'h003F_FFFF) << 10;
          m.sp = 14'((d & 32'h3FC0_0000) >> 16);
          m.st = d[30];
        end
        A_DST_PK: begin
          m.dof = (d & 32'h003F_FFFF) << 10;
          m.dp = 14'((d & 32'h3FC0_0000) >> 16);
          m.dt = d[30];
        end
        default: ;
      endcase
    end
    q.push_back(m);
  endtask

  // monitor: compare just after the edge that consumed each queued item
  always @(posedge clk) begin
    #2;
    if (rstN && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(e.tag, actual(), pack(e));
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    m = '{sx: '0, sy: '0, dx: '0, dy: '0, w: '0, h: '0, sp: '0, dp: '0,
          so: '0, dof: '0, st: 1'b0, dt: 1'b0, go: 1'b0, tag: ""};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset", actual(), '0);

    doWrite(A_SRC_X, 32'hFFFF_1234, 1, "R2 srcX");
    doWrite(A_SRC_Y, 32'h0000_2ABC, 1, "R2 srcY");
    doWrite(A_DST_X, 32'h5555_0111, 1, "R2 dstX");
    doWrite(A_DST_Y, 32'h0000_3FFF, 1, "R2 dstY");
    doWrite(A_HEIGHT, 32'h0000_0077, 1, "R6 height no start");
    doWrite(A_WIDTH, 32'h0000_0321, 1, "R5 width start");
    doWrite(0, 32'h0, 0, "R5 pulse one cycle");
    doWrite(A_SRC_YX, 32'h0ABC_0123, 1, "R3 src Y-X");
    doWrite(A_DST_YX, 32'h0456_0789, 1, "R3 dst Y-X");
    doWrite(A_SRC_XY, 32'h0111_0222, 1, "R3 src X-Y");
    doWrite(A_DST_XY, 32'h0333_0444, 1, "R3 dst X-Y");
    doWrite(A_HW, 32'h0010_0020, 1, "R4 height-width");
    doWrite(A_WH, 32'h0030_0040, 1, "R4 width-height");
    doWrite(A_WX, 32'h0050_0060, 1, "R4 width-X");
    doWrite(A_HY, 32'h0070_0080, 1, "R4 R6 height-Y no start");
    doWrite(A_WIDTH, 32'h0000_0001, 1, "R5 back-to-back 1");
    doWrite(A_WIDTH, 32'h0000_0002, 1, "R5 back-to-back 2");
    doWrite(A_SRC_PK, 32'hFFFF_FFFF, 1, "R7 src packed ones");
    doWrite(A_DST_PK, 32'h4A5A_5A5A, 1, "R7 dst packed");
    doWrite(A_SRC_OFF, 32'hFFFF_FFFF, 1, "R8 src offset mask");
    doWrite(A_SRC_PIT, 32'hFFFF_FFFF, 1, "R8 src pitch mask tile kept");
    doWrite(A_DST_OFF, 32'h1234_5678, 1, "R8 dst offset mask");
    doWrite(A_DST_PIT, 32'h0001_ABCD, 1, "R8 dst pitch mask tile kept");
    doWrite(20, 32'hFFFF_FFFF, 1, "R9 unknown 20");
    doWrite(31, 32'hFFFF_FFFF, 1, "R9 unknown 31");
    doWrite(A_WIDTH, 32'h0000_1FFF, 0, "R10 disabled width");
    doWrite(A_SRC_PK, 32'h0000_0000, 0, "R10 disabled packed");
    doWrite(A_DST_PK, 32'h3FC0_0001, 1, "R7 dst packed tile clear");
    doWrite(0, 32'h0, 0, "R6 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule